// File: doc/BRIEF.md
# Time-Slot Interchange Output Stage

This block builds the outgoing time slots of a TDM switch. A connection memory holds one entry for every output stream and channel. Each entry picks what its slot carries. It can carry a byte switched from any input stream and channel, with one of three delay rules. It can carry a fixed byte stored in the entry itself. It can carry a byte from a pseudo-random test generator. A spare code sends an idle byte.

Input traffic arrives already framed into bytes, one byte per stream for each channel time slot. It is written into a three-bank data memory, and the bank rotates at every frame. One clock cycle is one channel time slot. An internal channel counter walks through the frame, and a frame pulse forces it back to channel 0. A host port writes and reads connection entries. A write is held back until the next frame boundary, so every frame is switched with a consistent set of entries.

Top module: `tsi_out_switch`

## Requirements
- R1: While `rst` is high, every byte of `out_slot` reads 0xFF and `out_chan` reads 0 at the following clock edge.
- R2: An entry is 16 bits: mode in bits 15:13, source stream in bits 12:8, source channel in bits 7:0. Mode code 0 (message) puts entry bits 7:0 on the slot.
- R3: Mode code 1 (connection) outputs the source byte that was received in the previous frame.
- R4: Mode code 2 (constant delay) outputs the source byte that was received two frames earlier. The relative order of source and destination channels does not matter.
- R5: Mode code 3 (variable delay) outputs the source byte from the current frame when the source channel is lower than the destination channel. Otherwise it outputs the byte from the previous frame.
- R6: Mode code 4 (test) outputs the generator byte of that slot. The 15-bit generator starts at all ones when reset is released. In every slot it takes 8 steps, each computing fb = s[14]^s[13] and s = {s[13:0], fb}. The eight fb bits form the byte, first bit in the MSB. The byte comes from the state held at the start of the slot.
- R7: Mode codes 5, 6 and 7 output 0xFF.
- R8: A host write becomes visible to switching at the next frame start, where a frame start is a slot with channel 0. A write made during a channel-0 slot waits for the frame start after that one.
- R9: Only the low log2(streams) bits of the stream field and the low log2(channels) bits of the channel field select the source. Higher bits have no effect.
- R10: `cm_rd_data` returns, one cycle later, the most recently written value of the entry at `cm_addr`, including a write that is still waiting for the frame start. Entry address = stream * channels + channel.
- R11: Outputs are registered. `out_slot` and `out_chan` appear one cycle after their slot. `out_chan` counts up and wraps at the last channel. `frame_sync` makes its own slot channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one channel time slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Marks the current slot as channel 0 |
| in_slot | input | NS*8 | Received byte per input stream for the current slot, stream s in bits 8s+7:8s |
| cm_wr_en | input | 1 | Host write strobe for the connection memory |
| cm_addr | input | log2(NS*NCH) | Host entry address, {stream, channel} |
| cm_wdata | input | 16 | Host write data |
| cm_rd_data | output | 16 | Latest value of the entry addressed in the previous cycle |
| out_slot | output | NS*8 | Output byte per output stream, registered |
| out_chan | output | log2(NCH) | Channel that `out_slot` belongs to |

## Verification
The bench builds the block with 4 streams of 32 channels. This makes the 128-entry connection memory small enough to fill completely in four frames. After that, the run can cycle through dozens of frames with random entries and random traffic in a few thousand cycles. With a 32-slot frame, the bench reaches several cases quickly: variable-delay sources just before, at and just after their destination channel; the two-frame delay across bank wrap; and host writes that land on channel-0 slots. Random stream and channel fields fill all 5 and 8 bits, so the ignored upper bits are exercised throughout the run.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  typedef enum logic [2:0] {
    MODE_MSG   = 3'd0,
    MODE_CONN  = 3'd1,
    MODE_CONST = 3'd2,
    MODE_VAR   = 3'd3,
    MODE_TEST  = 3'd4
  } slot_mode_e;

  typedef struct packed {
    logic [2:0] mode;
    logic [4:0] src_stream;
    logic [7:0] src_chan;
  } tsi_entry_t;

  localparam int ENTRY_W = $bits(tsi_entry_t);

  // Eight generator steps: returns {byte, next_state}
  function automatic logic [22:0] prbs_adv8(input logic [14:0] s);
    logic [14:0] t;
    logic [7:0]  b;
    logic        fb;
    t = s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      fb       = t[14] ^ t[13];
      b[7 - i] = fb;
      t        = {t[13:0], fb};
    end
    return {b, t};
  endfunction

  function automatic logic [1:0] bank_inc(input logic [1:0] b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction

endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer import tsi_pkg::*; #(
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_sync,
  output logic [CW-1:0] cur_chan,
  output logic [1:0]    cur_bank,
  output logic [1:0]    prev_bank,
  output logic [1:0]    old_bank,
  output logic          new_frame
);
  localparam logic [CW-1:0] LAST_CH = CW'(NCH - 1);

  logic [CW-1:0] chan_q;
  logic [1:0]    bank_q;

  always_comb begin
    cur_chan  = frame_sync ? '0 : chan_q;
    cur_bank  = (frame_sync && chan_q != '0) ? bank_inc(bank_q) : bank_q;
    new_frame = (cur_chan == '0);
    prev_bank = (cur_bank == 2'd0) ? 2'd2 : cur_bank - 2'd1;
    old_bank  = bank_inc(cur_bank);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
      bank_q <= '0;
    end else if (cur_chan == LAST_CH) begin
      chan_q <= '0;
      bank_q <= bank_inc(cur_bank);
    end else begin
      chan_q <= cur_chan + 1'b1;
      bank_q <= cur_bank;
    end
  end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem import tsi_pkg::*; #(
  parameter int NS  = 4,
  parameter int NCH = 32,
  localparam int CW    = $clog2(NCH),
  localparam int SW    = $clog2(NS),
  localparam int AW    = SW + CW,
  localparam int DEPTH = NS * NCH
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         new_frame,
  input  logic                         wr_en,
  input  logic [AW-1:0]                addr,
  input  logic [ENTRY_W-1:0]           wr_data,
  output logic [ENTRY_W-1:0]           rd_data,
  input  logic [CW-1:0]                lk_chan,
  output logic [NS-1:0][ENTRY_W-1:0]   lk_entry
);
  // Two copies per entry; sel picks the live one, pend marks a waiting update
  logic [ENTRY_W-1:0] mem0 [DEPTH];
  logic [ENTRY_W-1:0] mem1 [DEPTH];
  logic [DEPTH-1:0]   sel_q, pend_q, eff_sel, pend_d;

  always_comb begin
    eff_sel = new_frame ? (sel_q ^ pend_q) : sel_q;
    pend_d  = new_frame ? '0 : pend_q;
    if (wr_en) pend_d[addr] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      pend_q <= '0;
    end else begin
      sel_q  <= eff_sel;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (eff_sel[addr]) mem0[addr] <= wr_data;
      else               mem1[addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= (sel_q[addr] ^ pend_q[addr]) ? mem1[addr] : mem0[addr];
  end

  for (genvar d = 0; d < NS; d++) begin : g_lookup
    logic [AW-1:0] idx;
    assign idx         = {SW'(d), lk_chan};
    assign lk_entry[d] = eff_sel[idx] ? mem1[idx] : mem0[idx];
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int NS  = 4,
  parameter int NCH = 32,
  localparam int CW    = $clog2(NCH),
  localparam int SW    = $clog2(NS),
  localparam int DEPTH = 3 * NS * NCH
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [1:0]              wr_bank,
  input  logic [CW-1:0]           wr_chan,
  input  logic [NS*8-1:0]         wr_bytes,
  input  logic [NS-1:0][1:0]      rd_bank,
  input  logic [NS-1:0][SW-1:0]   rd_stream,
  input  logic [NS-1:0][CW-1:0]   rd_chan,
  output logic [NS-1:0][7:0]      rd_bytes
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int s = 0; s < NS; s++) begin
        mem[(int'(wr_bank) * NS + s) * NCH + int'(wr_chan)] <= wr_bytes[s*8 +: 8];
      end
    end
  end

  for (genvar d = 0; d < NS; d++) begin : g_rd
    assign rd_bytes[d] =
      mem[(int'(rd_bank[d]) * NS + int'(rd_stream[d])) * NCH + int'(rd_chan[d])];
  end
endmodule

// File: rtl/tsi_prbs.sv
module tsi_prbs import tsi_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] byte_out
);
  logic [14:0] state_q;
  logic [22:0] adv;

  assign adv      = prbs_adv8(state_q);
  assign byte_out = adv[22:15];

  always_ff @(posedge clk) begin
    if (rst) state_q <= '1;
    else     state_q <= adv[14:0];
  end
endmodule

// File: rtl/tsi_out_switch.sv
module tsi_out_switch import tsi_pkg::*; #(
  parameter int NS  = 4,
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH),
  localparam int SW = $clog2(NS),
  localparam int AW = SW + CW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_sync,
  input  logic [NS*8-1:0]    in_slot,
  input  logic               cm_wr_en,
  input  logic [AW-1:0]      cm_addr,
  input  logic [ENTRY_W-1:0] cm_wdata,
  output logic [ENTRY_W-1:0] cm_rd_data,
  output logic [NS*8-1:0]    out_slot,
  output logic [CW-1:0]      out_chan
);
  logic [CW-1:0]              cur_chan;
  logic [1:0]                 cur_bank, prev_bank, old_bank;
  logic                       new_frame;
  logic                       host_we;
  logic [NS-1:0][ENTRY_W-1:0] lk_entry;
  logic [NS-1:0][1:0]         rd_bank;
  logic [NS-1:0][SW-1:0]      rd_stream;
  logic [NS-1:0][CW-1:0]      rd_chan;
  logic [NS-1:0][7:0]         rd_bytes;
  logic [NS-1:0][7:0]         slot_val;
  logic [NS-1:0][2:0]         slot_mode;
  logic [NS-1:0][7:0]         slot_msg;
  logic [7:0]                 test_byte;

  assign host_we = cm_wr_en & ~rst;

  tsi_slot_timer #(.NCH(NCH)) timer_i (
    .clk, .rst, .frame_sync,
    .cur_chan, .cur_bank, .prev_bank, .old_bank, .new_frame
  );

  tsi_conn_mem #(.NS(NS), .NCH(NCH)) cmem_i (
    .clk, .rst, .new_frame,
    .wr_en(host_we), .addr(cm_addr), .wr_data(cm_wdata), .rd_data(cm_rd_data),
    .lk_chan(cur_chan), .lk_entry
  );

  tsi_data_mem #(.NS(NS), .NCH(NCH)) dmem_i (
    .clk, .wr_en(~rst), .wr_bank(cur_bank), .wr_chan(cur_chan), .wr_bytes(in_slot),
    .rd_bank, .rd_stream, .rd_chan, .rd_bytes
  );

  tsi_prbs prbs_i (.clk, .rst, .byte_out(test_byte));

  for (genvar d = 0; d < NS; d++) begin : g_slot
    tsi_entry_t    ent;
    logic [CW-1:0] src_c;
    logic          unused_hi;

    assign ent          = tsi_entry_t'(lk_entry[d]);
    assign src_c        = ent.src_chan[CW-1:0];
    assign rd_stream[d] = ent.src_stream[SW-1:0];
    assign rd_chan[d]   = src_c;
    assign unused_hi    = ^ent.src_stream[4:SW];
    assign slot_mode[d] = ent.mode;
    assign slot_msg[d]  = ent.src_chan;

    always_comb begin
      case (ent.mode)
        MODE_CONN:  rd_bank[d] = prev_bank;
        MODE_CONST: rd_bank[d] = old_bank;
        MODE_VAR:   rd_bank[d] = (src_c < cur_chan) ? cur_bank : prev_bank;
        default:    rd_bank[d] = cur_bank;
      endcase
    end

    always_comb begin
      case (ent.mode)
        MODE_MSG:                      slot_val[d] = ent.src_chan;
        MODE_CONN, MODE_CONST, MODE_VAR: slot_val[d] = rd_bytes[d];
        MODE_TEST:                     slot_val[d] = test_byte;
        default:                       slot_val[d] = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_slot <= '1;
      out_chan <= '0;
    end else begin
      out_slot <= slot_val;
      out_chan <= cur_chan;
    end
  end
endmodule

// File: rtl/tsi_out_switch_chk.sv
module tsi_out_switch_chk #(
  parameter int NS  = 4,
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH),
  localparam int AW = $clog2(NS) + CW
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_sync,
  input logic [NS*8-1:0]    out_slot,
  input logic [CW-1:0]      out_chan,
  input logic               cm_wr_en,
  input logic [AW-1:0]      cm_addr,
  input logic [15:0]        cm_wdata,
  input logic [15:0]        cm_rd_data,
  input logic [NS-1:0][2:0] slot_mode,
  input logic [NS-1:0][7:0] slot_msg
);
  localparam logic [CW-1:0] LAST_CH = CW'(NCH - 1);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (out_slot == '1 && out_chan == '0)); // R1

  AST_SYNC_CHAN0: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> out_chan == '0); // R11

  AST_CHAN_STEP: assert property (@(posedge clk) disable iff (rst)
    (!frame_sync && !$past(rst)) |=>
      out_chan == (($past(out_chan) == LAST_CH) ? '0 : $past(out_chan) + 1'b1)); // R11

  AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    ($past(cm_wr_en) && !$past(rst) && !cm_wr_en && cm_addr == $past(cm_addr)) |=>
      cm_rd_data == $past(cm_wdata, 2)); // R10

  for (genvar d = 0; d < NS; d++) begin : g_chk
    AST_MSG_BYTE: assert property (@(posedge clk) disable iff (rst)
      (slot_mode[d] == 3'd0) |=> out_slot[d*8 +: 8] == $past(slot_msg[d])); // R2

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
      (slot_mode[d] >= 3'd5) |=> out_slot[d*8 +: 8] == 8'hFF); // R7
  end
endmodule

bind tsi_out_switch tsi_out_switch_chk #(.NS(NS), .NCH(NCH)) chk_i (
  .clk(clk), .rst(rst), .frame_sync(frame_sync), .out_slot(out_slot),
  .out_chan(out_chan), .cm_wr_en(cm_wr_en), .cm_addr(cm_addr),
  .cm_wdata(cm_wdata), .cm_rd_data(cm_rd_data),
  .slot_mode(slot_mode), .slot_msg(slot_msg)
);

// File: tb/tsi_out_switch_tb_top.sv
module tsi_out_switch_tb_top;
  localparam int NS  = 4;
  localparam int NCH = 32;
  localparam int NE  = NS * NCH;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_sync = 1'b0;
  logic [NS*8-1:0] in_slot = '0;
  logic          cm_wr_en = 1'b0;
  logic [6:0]    cm_addr = '0;
  logic [15:0]   cm_wdata = '0;
  logic [15:0]   cm_rd_data;
  logic [NS*8-1:0] out_slot;
  logic [4:0]    out_chan;

  always #4 clk = ~clk;

  tsi_out_switch #(.NS(NS), .NCH(NCH)) dut_i (
    .clk, .rst, .frame_sync, .in_slot, .cm_wr_en, .cm_addr, .cm_wdata,
    .cm_rd_data, .out_slot, .out_chan
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] staged [NE];
  logic [15:0] live   [NE];
  bit          pend   [NE];
  bit          known  [NE];
  bit          wrote  [NE];
  logic [7:0]  hist   [4][NS][NCH];
  logic [14:0] lfsr = '1;

  bit          exp_v = 1'b0;
  logic [4:0]  exp_chan;
  bit          exp_chk [NS];
  logic [7:0]  exp_b   [NS];
  string       exp_tag [NS];
  bit          rd_v = 1'b0;
  logic [15:0] rd_exp;

  function automatic logic [22:0] gen8(input logic [14:0] s);
    logic [14:0] t;
    logic [7:0]  b;
    t = s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      b[7 - i] = t[14] ^ t[13];
      t        = {t[13:0], t[14] ^ t[13]};
    end
    return {b, t};
  endfunction

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cmp_prev();
    if (exp_v) begin
      check(out_chan == exp_chan, "R11", out_chan, exp_chan);
      for (int d = 0; d < NS; d++)
        if (exp_chk[d])
          check(out_slot[d*8 +: 8] == exp_b[d], exp_tag[d], out_slot[d*8 +: 8], exp_b[d]);
    end
    if (rd_v) check(cm_rd_data == rd_exp, "R10", cm_rd_data, rd_exp);
  endtask

  task automatic slot(input bit fs, input int f, input int c, input bit wr,
                      input int waddr, input logic [15:0] wd, input bit chk_data);
    logic [22:0] g;
    @(negedge clk);
    cmp_prev();
    rst        = 1'b0;
    frame_sync = fs;
    in_slot    = {$urandom, $urandom};
    if (c == 0) begin
      for (int a = 0; a < NE; a++)
        if (pend[a]) begin
          live[a] = staged[a]; known[a] = 1'b1; pend[a] = 1'b0;
        end
    end
    g = gen8(lfsr);
    lfsr = g[14:0];
    exp_v    = 1'b1;
    exp_chan = 5'(c);
    for (int d = 0; d < NS; d++) begin
      int a, sf, ss, sc;
      logic [15:0] e;
      logic [2:0]  m;
      a = d * NCH + c;
      exp_chk[d] = 1'b0;
      if (known[a] && chk_data) begin
        e  = live[a];
        m  = e[15:13];
        ss = int'(e[9:8]);
        sc = int'(e[4:0]);
        exp_tag[d] = mode_tag(m);
        if (m >= 3'd1 && m <= 3'd3 && (e[12:10] != 0 || e[7:5] != 0))
          exp_tag[d] = {exp_tag[d], "/R9"};
        if (pend[a] && staged[a] != live[a]) exp_tag[d] = {exp_tag[d], "/R8"};
        sf = -1;
        case (m)
          3'd0: begin exp_b[d] = e[7:0]; exp_chk[d] = 1'b1; end
          3'd1: sf = f - 1;
          3'd2: sf = f - 2;
          3'd3: sf = (sc < c) ? f : f - 1;
          3'd4: begin exp_b[d] = g[22:15]; exp_chk[d] = 1'b1; end
          default: begin exp_b[d] = 8'hFF; exp_chk[d] = 1'b1; end
        endcase
        if (m >= 3'd1 && m <= 3'd3 && sf >= 0) begin
          exp_b[d]   = hist[sf % 4][ss][sc];
          exp_chk[d] = 1'b1;
        end
      end
    end
    for (int s = 0; s < NS; s++) hist[f % 4][s][c] = in_slot[s*8 +: 8];
    if (wr) begin
      cm_wr_en = 1'b1;
      cm_addr  = 7'(waddr);
      cm_wdata = wd;
      staged[waddr] = wd;
      pend[waddr]   = 1'b1;
      wrote[waddr]  = 1'b1;
      rd_v = 1'b0;
    end else begin
      int ra;
      ra = int'($urandom % NE);
      cm_wr_en = 1'b0;
      cm_addr  = 7'(ra);
      rd_v     = wrote[ra];
      rd_exp   = staged[ra];
    end
  endtask

  function automatic logic [15:0] rnd_entry();
    return {3'($urandom % 8), 13'($urandom)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < NE; a++) begin
      pend[a] = 0; known[a] = 0; wrote[a] = 0;
    end
    repeat (4) @(negedge clk);
    // R1: reset state
    check(out_slot == '1, "R1", out_slot, 32'hFFFFFFFF);
    check(out_chan == 0, "R1", out_chan, 0);

    // fill the whole connection memory, one entry per slot
    for (int f = 0; f < 4; f++)
      for (int c = 0; c < NCH; c++)
        slot(c == 0, f, c, 1'b1, f * NCH + c, rnd_entry(), 1'b1);

    // directed corners written in frame 4, live from frame 5
    for (int c = 0; c < NCH; c++) begin
      case (c)
        0: slot(1, 4, c, 1, 0*NCH + 5,  {3'd3, 5'd1, 8'd3},   1); // R5 source earlier
        1: slot(0, 4, c, 1, 0*NCH + 6,  {3'd3, 5'd2, 8'd6},   1); // R5 same channel
        2: slot(0, 4, c, 1, 0*NCH + 7,  {3'd3, 5'd0, 8'd20},  1); // R5 source later
        3: slot(0, 4, c, 1, 1*NCH + 8,  {3'd2, 5'h16, 8'hE9}, 1); // R9 upper bits, R4
        4: slot(0, 4, c, 1, 2*NCH + 9,  {3'd5, 13'h1ABC},     1); // R7
        5: slot(0, 4, c, 1, 2*NCH + 10, {3'd6, 13'h0001},     1); // R7
        6: slot(0, 4, c, 1, 2*NCH + 11, {3'd7, 13'h1FFF},     1); // R7
        7: slot(0, 4, c, 1, 3*NCH + 12, {3'd0, 5'h1F, 8'h5A}, 1); // R2
        8: slot(0, 4, c, 1, 3*NCH + 13, {3'd4, 13'h0},        1); // R6
        default: slot(0, 4, c, 0, 0, '0, 1);
      endcase
    end

    // random traffic with sparse host writes, including channel-0 writes (R8)
    for (int f = 5; f < 45; f++)
      for (int c = 0; c < NCH; c++) begin
        bit w;
        w = ($urandom % 6 == 0) || (c == 0 && f % 3 == 0);
        slot(c == 0, f, c, w, int'($urandom % NE), rnd_entry(), 1'b1);
      end

    // early frame pulse realigns the counter (R11)
    for (int c = 0; c < 10; c++) slot(c == 0, 45, c, 0, 0, '0, 0);
    for (int c = 0; c < 5; c++)  slot(c == 0, 46, c, 0, 0, '0, 0);
    @(negedge clk);
    cmp_prev();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule